// File: doc/BRIEF.md
# Multiply-Low-Word Execution Unit

This unit is a fixed-point execution slice. It multiplies two 32-bit two's-complement register operands and returns the least significant 32 bits of their 64-bit product. Along with the product it returns updated exception-register bits and a 4-bit condition nibble, each with its own write-enable. The issue logic presents one operation per cycle with a valid strobe. The two control bits, `ovf_en` and `rec_en`, may take any of their four combinations. Register-file access and decode stay outside the unit.

The unit is a two-stage pipeline with a fixed latency of two clock edges. Stage A registers the operands, the control bits and the incoming exception bits. Stage B forms the 64-bit signed product from the Stage A registers. It then registers the truncated word, the overflow and summary-overflow results, and the condition nibble. The valid strobe travels with the data, and every write-enable is qualified by the delayed valid. There is no state machine. The pipeline has no control state beyond the two valid bits, and a new operation may enter on every cycle.

Top module: `mlw_unit`

## Requirements
- R1: `res_word` equals the low 32 bits of the signed 64-bit product of `op_a` and `op_b`.
- R2: When `ovf_en`=1, `ov_we`=1 and `ov_out` is 1 exactly when the signed product lies outside [-2^31, 2^31-1]. Otherwise `ov_out` is 0.
- R3: When `ovf_en`=1, `so_we`=1 and `so_out` = `xer_so_in` OR the overflow of this operation. A set summary-overflow bit is never cleared.
- R4: The carry bit is never written: `ca_we` stays 0 and `ca_out` returns the `xer_ca_in` value that was issued with the operation.
- R5: When `rec_en`=1, `cond_we`=1 and the nibble holds the result compared with zero: bit 3 = negative, bit 2 = positive, bit 1 = zero. Exactly one of these three bits is set.
- R6: Bit 0 of the nibble is the summary-overflow value. When `ovf_en`=1 it is the updated value from R3; when `ovf_en`=0 it is `xer_so_in`.
- R7: When `rec_en`=0, `cond_we`=0. When `ovf_en`=0, `so_we`=0 and `ov_we`=0.
- R8: An operation issued with `op_valid`=1 before rising edge k appears with `res_valid`=1 after edge k+1. Operations issued on consecutive cycles come out on consecutive cycles, in issue order.
- R9: When no operation is completing (`res_valid`=0), all write-enables are 0. After reset, `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ovf_en | input | 1 | Overflow-recording form |
| rec_en | input | 1 | Condition-recording form |
| xer_so_in | input | 1 | Current summary-overflow bit |
| xer_ov_in | input | 1 | Current overflow bit |
| xer_ca_in | input | 1 | Current carry bit |
| res_valid | output | 1 | Result completing this cycle |
| res_word | output | 32 | Low word of the product |
| cond_nib | output | 4 | {neg, pos, zero, so} |
| cond_we | output | 1 | Write condition nibble |
| so_out | output | 1 | New summary-overflow bit |
| so_we | output | 1 | Write summary-overflow bit |
| ov_out | output | 1 | New overflow bit |
| ov_we | output | 1 | Write overflow bit |
| ca_out | output | 1 | Carry bit (unchanged) |
| ca_we | output | 1 | Write carry bit |

## Verification
The overflow boundary is the main target. The bench uses 0x80000000 × 1, whose product fits, and 0x80000000 × -1 (+2^31), which does not fit but whose low word looks the same. A design that tests only the high 32 bits, or that treats the operands as unsigned, flags or misses one of these. A second group checks that summary-overflow stays set when there is no new overflow, and that the nibble's SO bit takes the updated value when both forms are set. A design that copies the incoming SO, or that clears it, gives the wrong nibble. Back-to-back issue and idle cycles expose misaligned valid delays and write-enables that are not qualified by valid.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
    // control and exception bits carried with an operation
    typedef struct packed {
        logic oe;
        logic rc;
        logic so;
        logic ov;
        logic ca;
    } mlw_ctl_t;

    localparam int unsigned COND_W = 4;
endpackage

// File: rtl/mlw_stage_a.sv
module mlw_stage_a
    import mlw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  mlw_ctl_t     in_ctl,
    output logic         a_valid,
    output logic [W-1:0] a_op1,
    output logic [W-1:0] a_op2,
    output mlw_ctl_t     a_ctl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_op1   <= '0;
            a_op2   <= '0;
            a_ctl   <= '0;
        end else begin
            a_valid <= in_valid;
            a_op1   <= in_a;
            a_op2   <= in_b;
            a_ctl   <= in_ctl;
        end
    end
endmodule

// File: rtl/mlw_cond_gen.sv
module mlw_cond_gen
    import mlw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              [W-1:0] word,
    input  logic                      so_bit,
    output logic         [COND_W-1:0] nib
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = word[W-1];
        is_zero = ~|word;
        nib     = {is_neg, ~is_neg & ~is_zero, is_zero, so_bit};
    end
endmodule

// File: rtl/mlw_stage_b.sv
module mlw_stage_b
    import mlw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic [W-1:0]      a_op1,
    input  logic [W-1:0]      a_op2,
    input  mlw_ctl_t          a_ctl,
    output logic              b_valid,
    output logic [W-1:0]      b_word,
    output logic [COND_W-1:0] b_nib,
    output logic              b_cond_we,
    output logic              b_so,
    output logic              b_so_we,
    output logic              b_ov,
    output logic              b_ov_we,
    output logic              b_ca
);
    localparam int unsigned PW = 2 * W;

    logic signed [PW-1:0] prod;
    logic [W:0]           upper;
    logic                 ovf;
    logic                 so_next;
    logic                 so_nib;
    logic [COND_W-1:0]    nib_next;

    always_comb begin
        prod    = $signed({{W{a_op1[W-1]}}, a_op1}) * $signed({{W{a_op2[W-1]}}, a_op2});
        upper   = prod[PW-1:W-1];
        ovf     = ~((&upper) | (~|upper));
        so_next = a_ctl.so | ovf;
        so_nib  = a_ctl.oe ? so_next : a_ctl.so;
    end

    mlw_cond_gen #(.W(W)) u_cond (
        .word   (prod[W-1:0]),
        .so_bit (so_nib),
        .nib    (nib_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_valid   <= 1'b0;
            b_word    <= '0;
            b_nib     <= '0;
            b_cond_we <= 1'b0;
            b_so      <= 1'b0;
            b_so_we   <= 1'b0;
            b_ov      <= 1'b0;
            b_ov_we   <= 1'b0;
            b_ca      <= 1'b0;
        end else begin
            b_valid   <= a_valid;
            b_word    <= prod[W-1:0];
            b_nib     <= nib_next;
            b_cond_we <= a_valid & a_ctl.rc;
            b_so      <= a_ctl.oe ? so_next : a_ctl.so;
            b_so_we   <= a_valid & a_ctl.oe;
            b_ov      <= a_ctl.oe ? ovf : a_ctl.ov;
            b_ov_we   <= a_valid & a_ctl.oe;
            b_ca      <= a_ctl.ca;
        end
    end

    // R3: a set incoming summary bit survives an overflow-recording op
    p_so_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ctl.oe && a_ctl.so) |=> (b_so_we && b_so));

    // R2: a recorded overflow always comes with the summary bit
    p_ov_implies_so_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ov_we && b_ov) |-> b_so);

    // R5: exactly one of neg/pos/zero in a recorded nibble
    p_cond_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        b_cond_we |-> ($countones(b_nib[3:1]) == 1));
endmodule

// File: rtl/mlw_unit.sv
module mlw_unit
    import mlw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic              ovf_en,
    input  logic              rec_en,
    input  logic              xer_so_in,
    input  logic              xer_ov_in,
    input  logic              xer_ca_in,
    output logic              res_valid,
    output logic [W-1:0]      res_word,
    output logic [COND_W-1:0] cond_nib,
    output logic              cond_we,
    output logic              so_out,
    output logic              so_we,
    output logic              ov_out,
    output logic              ov_we,
    output logic              ca_out,
    output logic              ca_we
);
    mlw_ctl_t     in_ctl;
    logic         a_valid;
    logic [W-1:0] a_op1;
    logic [W-1:0] a_op2;
    mlw_ctl_t     a_ctl;

    always_comb begin
        in_ctl.oe = ovf_en;
        in_ctl.rc = rec_en;
        in_ctl.so = xer_so_in;
        in_ctl.ov = xer_ov_in;
        in_ctl.ca = xer_ca_in;
    end

    mlw_stage_a #(.W(W)) u_sa (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (op_valid),
        .in_a     (op_a),
        .in_b     (op_b),
        .in_ctl   (in_ctl),
        .a_valid  (a_valid),
        .a_op1    (a_op1),
        .a_op2    (a_op2),
        .a_ctl    (a_ctl)
    );

    mlw_stage_b #(.W(W)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_valid   (a_valid),
        .a_op1     (a_op1),
        .a_op2     (a_op2),
        .a_ctl     (a_ctl),
        .b_valid   (res_valid),
        .b_word    (res_word),
        .b_nib     (cond_nib),
        .b_cond_we (cond_we),
        .b_so      (so_out),
        .b_so_we   (so_we),
        .b_ov      (ov_out),
        .b_ov_we   (ov_we),
        .b_ca      (ca_out)
    );

    // carry is never touched by this operation (R4)
    assign ca_we = 1'b0;

    // R9: no write-enable without a completing operation
    p_we_need_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we || so_we || ov_we) |-> res_valid);

    // R6: with both forms, nibble SO equals the written SO
    p_cond_so_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we && so_we) |-> (cond_nib[0] == so_out));

    // R8: an op in stage A completes on the next edge
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |=> res_valid);
endmodule

// File: tb/mlw_unit_tb_top.sv
module mlw_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        ovf_en = 1'b0;
    logic        rec_en = 1'b0;
    logic        xer_so_in = 1'b0;
    logic        xer_ov_in = 1'b0;
    logic        xer_ca_in = 1'b0;
    logic        res_valid;
    logic [31:0] res_word;
    logic [3:0]  cond_nib;
    logic        cond_we;
    logic        so_out;
    logic        so_we;
    logic        ov_out;
    logic        ov_we;
    logic        ca_out;
    logic        ca_we;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mlw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .ovf_en(ovf_en), .rec_en(rec_en), .xer_so_in(xer_so_in),
        .xer_ov_in(xer_ov_in), .xer_ca_in(xer_ca_in), .res_valid(res_valid),
        .res_word(res_word), .cond_nib(cond_nib), .cond_we(cond_we),
        .so_out(so_out), .so_we(so_we), .ov_out(ov_out), .ov_we(ov_we),
        .ca_out(ca_out), .ca_we(ca_we)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // expected values computed from the requirements
    typedef struct {
        logic [31:0] word;
        logic [3:0]  nib;
        logic        cwe, so, swe, ov, owe, ca;
    } exp_t;

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input bit oe, input bit rc, input bit so,
                                   input bit ov, input bit ca);
        exp_t e;
        longint p;
        bit of, sn;
        p = longint'($signed(a)) * longint'($signed(b));
        of = (p > 64'sd2147483647) || (p < -64'sd2147483648);
        e.word = p[31:0];
        sn = oe ? (so | of) : so;
        e.nib = {($signed(e.word) < 0), ($signed(e.word) > 0), (e.word == 0), sn};
        e.cwe = rc;
        e.so = sn;
        e.swe = oe;
        e.ov = oe ? of : ov;
        e.owe = oe;
        e.ca = ca;
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input bit oe,
                         input bit rc, input bit so, input bit ov, input bit ca);
        op_valid = 1'b1; op_a = a; op_b = b; ovf_en = oe; rec_en = rc;
        xer_so_in = so; xer_ov_in = ov; xer_ca_in = ca;
    endtask

    task automatic idle_in();
        op_valid = 1'b0; op_a = '0; op_b = '0; ovf_en = 1'b0; rec_en = 1'b0;
        xer_so_in = 1'b0; xer_ov_in = 1'b0; xer_ca_in = 1'b0;
    endtask

    task automatic check_out(input exp_t e, input string nm);
        chk(res_valid == 1'b1, {nm, " R8 valid"}, 32'(res_valid), 32'd1);
        chk(res_word == e.word, {nm, " R1 word"}, res_word, e.word);
        chk(cond_we == e.cwe, {nm, " R7 cond_we"}, 32'(cond_we), 32'(e.cwe));
        if (e.cwe) begin
            chk(cond_nib[3:1] == e.nib[3:1], {nm, " R5 nib"}, 32'(cond_nib), 32'(e.nib));
            chk(cond_nib[0] == e.nib[0], {nm, " R6 nib so"}, 32'(cond_nib), 32'(e.nib));
        end
        chk(so_we == e.swe && ov_we == e.owe, {nm, " R7 so/ov we"},
            32'({so_we, ov_we}), 32'({e.swe, e.owe}));
        if (e.owe) begin
            chk(ov_out == e.ov, {nm, " R2 ov"}, 32'(ov_out), 32'(e.ov));
            chk(so_out == e.so, {nm, " R3 so"}, 32'(so_out), 32'(e.so));
        end
        chk(ca_we == 1'b0 && ca_out == e.ca, {nm, " R4 ca"},
            32'({ca_we, ca_out}), 32'({1'b0, e.ca}));
    endtask

    // single op: drive, two edges, sample at the second negedge
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit oe,
                          input bit rc, input bit so, input bit ov, input bit ca,
                          input string nm);
        exp_t e;
        e = model(a, b, oe, rc, so, ov, ca);
        @(negedge clk); drive(a, b, oe, rc, so, ov, ca);
        @(negedge clk); idle_in();
        @(negedge clk); check_out(e, nm);
    endtask

    task automatic t_reset();
        chk(res_valid == 1'b0, "R9 reset valid", 32'(res_valid), 32'd0);
        chk({cond_we, so_we, ov_we, ca_we} == 4'b0, "R9 reset we",
            32'({cond_we, so_we, ov_we, ca_we}), 32'd0);
    endtask

    task automatic t_examples();
        run_op(32'h00003000, 32'h00007000, 0, 0, 0, 0, 0, "plain");
        chk(res_word == 32'h15000000, "R1 plain literal", res_word, 32'h15000000);
        run_op(32'h00004500, 32'h00007000, 0, 1, 0, 0, 1, "rec");
        chk(cond_nib == 4'h4, "R5 rec literal", 32'(cond_nib), 32'h4);
        run_op(32'h00004500, 32'h00070000, 1, 0, 0, 0, 0, "ovf");
        chk(res_word == 32'hE3000000 && ov_out && so_out, "R2 ovf literal",
            res_word, 32'hE3000000);
        run_op(32'h00004500, 32'h7FFFFFFF, 1, 1, 0, 0, 0, "ovfrec");
        chk(cond_nib == 4'h9, "R6 ovfrec literal", 32'(cond_nib), 32'h9);
    endtask

    task automatic t_signed_edges();
        run_op(32'hFFFFFFFD, 32'hFFFFFFFB, 1, 1, 0, 1, 0, "negneg");
        run_op(32'h80000000, 32'h00000001, 1, 1, 0, 0, 0, "minfit");
        chk(ov_out == 1'b0, "R2 min*1 fits", 32'(ov_out), 32'd0);
        run_op(32'h80000000, 32'hFFFFFFFF, 1, 1, 0, 0, 0, "minneg");
        chk(ov_out == 1'b1, "R2 min*-1 overflows", 32'(ov_out), 32'd1);
        run_op(32'h12345678, 32'h00000000, 1, 1, 0, 0, 1, "zero");
        chk(cond_nib[3:1] == 3'b001, "R5 zero eq", 32'(cond_nib), 32'h2);
        run_op(32'h00010000, 32'h00010000, 1, 0, 0, 0, 0, "pow2");
    endtask

    task automatic t_sticky();
        run_op(32'h00000002, 32'h00000003, 1, 1, 1, 1, 0, "sticky");
        chk(so_out == 1'b1 && ov_out == 1'b0, "R3 sticky so kept ov cleared",
            32'({so_out, ov_out}), 32'b10);
        run_op(32'h00000002, 32'h00000003, 0, 1, 1, 0, 0, "recso");
        chk(cond_nib[0] == 1'b1, "R6 incoming so in nib", 32'(cond_nib), 32'h5);
        run_op(32'h40000000, 32'h00000004, 0, 0, 0, 0, 1, "noform");
    endtask

    task automatic t_stream();
        exp_t e [4];
        logic [31:0] av [4] = '{32'h7FFFFFFF, 32'hFFFF0000, 32'h00000007, 32'h00020000};
        logic [31:0] bv [4] = '{32'h00000002, 32'h00010000, 32'hFFFFFFF9, 32'h00008000};
        for (int i = 0; i < 4; i++)
            e[i] = model(av[i], bv[i], i[0], i[1], 0, 0, i[0]);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) check_out(e[i-2], "stream");
            if (i < 4) drive(av[i], bv[i], i[0], i[1], 0, 0, i[0]);
            else idle_in();
        end
        @(negedge clk);
        chk(res_valid == 1'b0 && {cond_we, so_we, ov_we} == 3'b0, "R9 idle after stream",
            32'({res_valid, cond_we, so_we, ov_we}), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_signed_edges();
        t_sticky();
        t_stream();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule